// File: doc/BRIEF.md
# Dual-Mode PWM Channel Pair

This block holds two pulse-width modulation channels. Each channel has a counter that advances on its own clock-enable tick. The counter is either edge-aligned (a sawtooth) or center-aligned (a triangle). The output pin is high or low depending on whether the count lies below the active duty value, and a polarity bit chooses which level counts as active.

Software writes period and duty values into buffer registers. The channel copies them into its active registers only at safe points:
- at the end of a period,
- when software writes the counter,
- at any time while the channel is stopped.

A write to a counter resets it at once, whatever data the write carries. A chaining bit joins the two channels into one 16-bit channel. In that mode channel 1 holds the high byte, and a read of the high counter byte freezes the low byte so that a following low-byte read stays coherent.

The block is driven through a small byte-wide register bus with separate write and read strobes. The clock-enable ticks come from a prescaler outside the block.

Top module: `pwm_pair`

## Requirements
- R1: After a synchronous reset all registers and both counters read 0. Both channels are stopped with polarity 0, so `pwm_o` is 2'b11.
- R2: Edge-aligned mode (center bit 0). With period P > 0, the counter advances by one on each cycle in which the channel's own tick is high. It runs 0, 1, ..., P-1 and then returns to 0. A tick on the other channel has no effect on it.
- R3: Center-aligned mode (center bit 1). With period P > 0, the counter runs up 0, 1, ..., P and then down P-1, ..., 1, 0. One full cycle takes 2P ticks.
- R4: Any write to a counter address resets that counter to 0, whatever the data. The count direction becomes up, and the buffered period and duty are copied into the active registers in the same cycle. The output then shows the active level when the duty is above 0.
- R5: While a channel's run bit is 0, its counter holds its value and its output sits at the inactive level. When the run bit is set again, counting resumes from the held value.
- R6: Buffered period and duty reach the active registers only at the end of a period, on a counter write, or while the channel is stopped.
  - In edge-aligned mode the end of a period is the wrap from P-1 to 0.
  - In center-aligned mode it is the turn at 0 after counting down.
- R7: Output rule. The channel is active when it runs, P != 0, and either duty >= P or count < duty. The pin equals active when polarity is 1 and the inverse of active when polarity is 0. A period of 0 therefore gives the inactive level, and a duty of P or more gives a full active level.
- R8: Reading any register leaves the counters and outputs unchanged.
- R9: Chained mode (control bit 6) behaves as follows.
  - Channel 1's run, polarity and center bits and `tick_i[1]` drive a 16-bit counter.
  - The period is {PER1, PER0} and the duty is {DUTY1, DUTY0}.
  - The output appears on `pwm_o[1]`, and `pwm_o[0]` is held at 0.
  - A write to either counter address resets the whole 16-bit counter.
- R10: In chained mode a read of address 6 returns the high counter byte and latches the low byte. The next read of address 5 returns the latched byte. Later reads of address 5 return the live low byte again.
- R11: Address map:
  - 0: control, with bits [1:0] run, [3:2] polarity, [5:4] center, [6] chain; bit 0 of each pair belongs to channel 0
  - 1: period buffer of channel 0; 2: period buffer of channel 1
  - 3: duty buffer of channel 0; 4: duty buffer of channel 1
  - 5: counter of channel 0; 6: counter of channel 1

  Reads of addresses 0 to 4 return the written values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (acts only on the coherent-read latch) |
| addr | input | 3 | Register address |
| wdata | input | CW | Write data |
| tick_i | input | 2 | Per-channel count enable ticks |
| rdata | output | CW | Read data, combinational from `addr` |
| pwm_o | output | 2 | Channel outputs |

## Verification
The bench builds the block with CW = 8, which gives 8-bit channels and a 16-bit chained counter. Channel 0 is swept over every period from 0 to 5 and every duty from 0 to 6, in both alignments and both polarities. Each sweep runs more than one full cycle of ticks and compares the counter and the pin against an arithmetic model, which covers the zero-period case, full duty and both turning points of the triangle. Directed runs in chained mode count past 255 so that the carry into the high byte, the 16-bit wrap and the coherent low-byte latch are all reached.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 3'd0,
        RA_PER0  = 3'd1,
        RA_PER1  = 3'd2,
        RA_DUTY0 = 3'd3,
        RA_DUTY1 = 3'd4,
        RA_CNT0  = 3'd5,
        RA_CNT1  = 3'd6
    } reg_addr_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    // control register layout, MSB first: chain, center[1:0], pol_hi[1:0], run[1:0]
    typedef struct packed {
        logic       chain;
        logic [1:0] center;
        logic [1:0] pol_hi;
        logic [1:0] run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // per-channel drive from the register layer to a counter core
    typedef struct packed {
        logic run;
        logic center;
        logic pol_hi;
        logic tick;
        logic clr;
    } chan_cfg_t;

    function automatic logic pin_level(input logic active, input logic pol_hi);
        return pol_hi ? active : ~active;
    endfunction

endpackage

// File: rtl/pwm_outgen.sv
module pwm_outgen
    import pwm_pair_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         run,
    input  logic         pol_hi,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] per,
    input  logic [W-1:0] duty,
    output logic         pwm
);

    logic per_zero;
    logic full_duty;
    logic below;
    logic active;

    always_comb begin
        per_zero  = (per == '0);
        full_duty = (duty >= per);
        below     = (cnt < duty);
        active    = run && !per_zero && (full_duty || below);
        pwm       = pin_level(active, pol_hi);
    end

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_pair_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  chan_cfg_t    cfg,
    input  logic [W-1:0] per_buf,
    input  logic [W-1:0] duty_buf,
    output logic [W-1:0] cnt_o,
    output logic         pwm_o
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q, cnt_n;
    logic [W-1:0] per_a, duty_a;
    cnt_dir_e     dir_q, dir_n;
    logic         load;
    logic         period_end;

    // next count, direction and buffer-load decision
    always_comb begin
        cnt_n      = cnt_q;
        dir_n      = dir_q;
        period_end = 1'b0;
        if (cfg.clr) begin
            cnt_n = '0;
            dir_n = DIR_UP;
        end else if (cfg.run && cfg.tick) begin
            if (per_a == '0) begin
                cnt_n      = '0;
                dir_n      = DIR_UP;
                period_end = 1'b1;
            end else if (!cfg.center) begin
                dir_n = DIR_UP;
                if (cnt_q >= per_a - ONE) begin
                    cnt_n      = '0;
                    period_end = 1'b1;
                end else begin
                    cnt_n = cnt_q + ONE;
                end
            end else if (dir_q == DIR_UP) begin
                if (cnt_q >= per_a) begin
                    cnt_n = cnt_q - ONE;
                    dir_n = DIR_DOWN;
                end else begin
                    cnt_n = cnt_q + ONE;
                end
            end else begin
                if (cnt_q == '0) begin
                    cnt_n      = ONE;
                    dir_n      = DIR_UP;
                    period_end = 1'b1;
                end else begin
                    cnt_n = cnt_q - ONE;
                end
            end
        end
        load = cfg.clr || !cfg.run || period_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            dir_q  <= DIR_UP;
            per_a  <= '0;
            duty_a <= '0;
        end else begin
            cnt_q <= cnt_n;
            dir_q <= dir_n;
            if (load) begin
                per_a  <= per_buf;
                duty_a <= duty_buf;
            end
        end
    end

    // R2: edge-aligned wrap at period minus one
    p_left_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg.run && cfg.tick && !cfg.clr && !cfg.center && per_a != '0 && cnt_q >= per_a - ONE)
        |=> (cnt_q == '0));

    // R3: center-aligned count turns down at the period value
    p_center_turn_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg.run && cfg.tick && !cfg.clr && cfg.center && per_a != '0 && dir_q == DIR_UP && cnt_q >= per_a)
        |=> (dir_q == DIR_DOWN && cnt_q == $past(cnt_q) - ONE));

    // R4: counter write clears count and direction, loads buffers
    p_clr_reset_r4: assert property (@(posedge clk) disable iff (rst)
        cfg.clr |=> (cnt_q == '0 && dir_q == DIR_UP && per_a == $past(per_buf) && duty_a == $past(duty_buf)));

    // R5: a stopped channel holds its count
    p_hold_stopped_r5: assert property (@(posedge clk) disable iff (rst)
        (!cfg.run && !cfg.clr) |=> $stable(cnt_q));

    // R6: active values move only at the allowed points
    p_buffer_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg.run && !cfg.clr && !period_end) |=> ($stable(per_a) && $stable(duty_a)));

    pwm_outgen #(.W(W)) u_out (
        .run    (cfg.run),
        .pol_hi (cfg.pol_hi),
        .cnt    (cnt_q),
        .per    (per_a),
        .duty   (duty_a),
        .pwm    (pwm_o)
    );

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pair_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [CW-1:0]         wdata,
    input  logic [CW-1:0]         cnt0_i,
    input  logic [2*CW-1:0]       cnt1_i,
    output ctrl_t                 ctrl_o,
    output logic [1:0][CW-1:0]    per_o,
    output logic [1:0][CW-1:0]    duty_o,
    output logic [1:0]            clr_o,
    output logic [CW-1:0]         rdata
);

    localparam int DW = 2 * CW;

    ctrl_t             ctrl_q;
    logic [1:0][CW-1:0] per_q, duty_q;
    logic [CW-1:0]     low_hold_q;
    logic              low_pend_q;
    reg_addr_e         ra;

    assign ra = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && ra == RA_CTRL) begin
            ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    // one period buffer and one duty buffer per channel
    for (genvar ch = 0; ch < 2; ch++) begin : g_buf
        localparam reg_addr_e PER_A  = (ch == 0) ? RA_PER0 : RA_PER1;
        localparam reg_addr_e DUTY_A = (ch == 0) ? RA_DUTY0 : RA_DUTY1;
        always_ff @(posedge clk) begin
            if (rst) begin
                per_q[ch]  <= '0;
                duty_q[ch] <= '0;
            end else if (wr_en) begin
                if (ra == PER_A)  per_q[ch]  <= wdata;
                if (ra == DUTY_A) duty_q[ch] <= wdata;
            end
        end
    end

    // coherent low-byte latch for the chained counter
    always_ff @(posedge clk) begin
        if (rst) begin
            low_hold_q <= '0;
            low_pend_q <= 1'b0;
        end else if (rd_en && ctrl_q.chain) begin
            if (ra == RA_CNT1) begin
                low_hold_q <= cnt1_i[CW-1:0];
                low_pend_q <= 1'b1;
            end else if (ra == RA_CNT0) begin
                low_pend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        clr_o[0] = wr_en && (ra == RA_CNT0) && !ctrl_q.chain;
        clr_o[1] = wr_en && ((ra == RA_CNT1) || ((ra == RA_CNT0) && ctrl_q.chain));
    end

    always_comb begin
        unique case (ra)
            RA_CTRL:  rdata = CW'(ctrl_q);
            RA_PER0:  rdata = per_q[0];
            RA_PER1:  rdata = per_q[1];
            RA_DUTY0: rdata = duty_q[0];
            RA_DUTY1: rdata = duty_q[1];
            RA_CNT0:  rdata = ctrl_q.chain ? (low_pend_q ? low_hold_q : cnt1_i[CW-1:0]) : cnt0_i;
            RA_CNT1:  rdata = ctrl_q.chain ? cnt1_i[DW-1:CW] : cnt1_i[CW-1:0];
            default:  rdata = '0;
        endcase
    end

    // R10: a high-byte read in chained mode arms the latch with the live low byte
    p_latch_arm_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && ctrl_q.chain && ra == RA_CNT1) |=> (low_pend_q && low_hold_q == $past(cnt1_i[CW-1:0])));

    // R9: in chained mode a write to either counter byte never clears channel 0
    p_chain_clr_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.chain |-> !clr_o[0]);

    assign ctrl_o = ctrl_q;
    assign per_o  = per_q;
    assign duty_o = duty_q;

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
    import pwm_pair_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CW-1:0]     wdata,
    input  logic [1:0]        tick_i,
    output logic [CW-1:0]     rdata,
    output logic [1:0]        pwm_o
);

    localparam int DW = 2 * CW;

    ctrl_t              ctrl;
    logic [1:0][CW-1:0] per_b, duty_b;
    logic [1:0]         clr;
    logic [CW-1:0]      cnt0;
    logic [DW-1:0]      cnt1;
    logic [DW-1:0]      per1_w, duty1_w;
    chan_cfg_t          cfg0, cfg1;
    logic               pwm0_raw, pwm1_raw;

    pwm_regs #(.CW(CW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .cnt0_i (cnt0),
        .cnt1_i (cnt1),
        .ctrl_o (ctrl),
        .per_o  (per_b),
        .duty_o (duty_b),
        .clr_o  (clr),
        .rdata  (rdata)
    );

    always_comb begin
        cfg0.run    = ctrl.run[0] && !ctrl.chain;
        cfg0.center = ctrl.center[0];
        cfg0.pol_hi = ctrl.pol_hi[0];
        cfg0.tick   = tick_i[0] && !ctrl.chain;
        cfg0.clr    = clr[0];

        cfg1.run    = ctrl.run[1];
        cfg1.center = ctrl.center[1];
        cfg1.pol_hi = ctrl.pol_hi[1];
        cfg1.tick   = tick_i[1];
        cfg1.clr    = clr[1];

        per1_w  = ctrl.chain ? {per_b[1], per_b[0]}   : {{CW{1'b0}}, per_b[1]};
        duty1_w = ctrl.chain ? {duty_b[1], duty_b[0]} : {{CW{1'b0}}, duty_b[1]};
    end

    pwm_core #(.W(CW)) u_ch0 (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg0),
        .per_buf  (per_b[0]),
        .duty_buf (duty_b[0]),
        .cnt_o    (cnt0),
        .pwm_o    (pwm0_raw)
    );

    pwm_core #(.W(DW)) u_ch1 (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg1),
        .per_buf  (per1_w),
        .duty_buf (duty1_w),
        .cnt_o    (cnt1),
        .pwm_o    (pwm1_raw)
    );

    assign pwm_o[0] = ctrl.chain ? 1'b0 : pwm0_raw;
    assign pwm_o[1] = pwm1_raw;

    // R8: a read strobe alone never moves a counter
    p_read_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && tick_i == 2'b00) |=> ($stable(cnt0) && $stable(cnt1)));

endmodule

// File: tb/tb_pwm_pair.sv
module tb_pwm_pair;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en, rd_en;
    logic [2:0]    addr;
    logic [CW-1:0] wdata;
    logic [1:0]    tick_i;
    logic [CW-1:0] rdata;
    logic [1:0]    pwm_o;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;   // 250 MHz

    pwm_pair #(.CW(CW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .tick_i(tick_i), .rdata(rdata), .pwm_o(pwm_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // all tasks start and end one time unit after a rising edge
    task automatic bus_wr(input int a, input int d);
        addr = 3'(a); wdata = CW'(d); wr_en = 1'b1;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic bus_rd(input int a, output int d);
        addr = 3'(a); rd_en = 1'b1;
        @(negedge clk); d = int'(rdata);
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic step(input logic [1:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = m;
            @(posedge clk); #1 tick_i = 2'b00;
        end
    endtask

    function automatic int model_cnt(input int k, input int per, input bit center);
        int ph;
        if (per == 0) return 0;
        if (!center) return k % per;
        ph = k % (2 * per);
        return (ph <= per) ? ph : 2 * per - ph;
    endfunction

    function automatic int model_pin(input int cnt, input int per, input int duty,
                                     input bit pol, input bit run);
        bit act;
        act = run && per != 0 && (duty >= per || cnt < duty);
        return pol ? int'(act) : int'(!act);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int d;
        int cnt;
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; tick_i = 2'b00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 / R11: reset state
        for (int a = 0; a < 7; a++) begin
            bus_rd(a, d);
            check("R1 reset register", d, 0);
        end
        check("R1 reset pins", int'(pwm_o), 3);

        // R11: buffer registers read back
        bus_wr(1, 8'h5A); bus_wr(2, 8'hC3); bus_wr(3, 8'h11); bus_wr(4, 8'hFE);
        bus_rd(1, d); check("R11 PER0", d, 8'h5A);
        bus_rd(2, d); check("R11 PER1", d, 8'hC3);
        bus_rd(3, d); check("R11 DUTY0", d, 8'h11);
        bus_rd(4, d); check("R11 DUTY1", d, 8'hFE);
        bus_wr(0, 8'h35); bus_rd(0, d); check("R11 CTRL", d, 8'h35);
        bus_wr(0, 0);

        // R2 R3 R7: sweep channel 0 over period, duty, alignment, polarity
        for (int ce = 0; ce < 2; ce++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int per = 0; per < 6; per++) begin
                    for (int duty = 0; duty < 7; duty++) begin
                        bus_wr(0, 0);
                        bus_wr(1, per);
                        bus_wr(3, duty);
                        bus_wr(0, 1 | (pol << 2) | (ce << 4));
                        bus_wr(5, 8'hA5);
                        for (int k = 0; k <= 2 * per + 2; k++) begin
                            if (k > 0) step(2'b01, 1);
                            cnt = model_cnt(k, per, ce[0]);
                            check(ce ? "R3 center count pin" : "R7 edge pin",
                                  int'(pwm_o[0]), model_pin(cnt, per, duty, pol[0], 1'b1));
                            bus_rd(5, d);
                            check(ce ? "R3 center count" : "R2 edge count", d, cnt);
                        end
                    end
                end
            end
        end

        // R5: stop holds count and forces inactive level; restart resumes
        bus_wr(0, 0); bus_wr(1, 5); bus_wr(3, 4);
        bus_wr(0, 8'h05);
        bus_wr(5, 0);
        step(2'b01, 3);
        check("R5 running pin", int'(pwm_o[0]), 1);
        step(2'b10, 2);
        bus_rd(5, d); check("R2 other tick ignored", d, 3);
        bus_wr(0, 8'h04);
        check("R5 stopped pin", int'(pwm_o[0]), 0);
        step(2'b01, 2);
        bus_rd(5, d); check("R5 stopped hold", d, 3);
        bus_wr(0, 8'h05);
        step(2'b01, 1);
        bus_rd(5, d); check("R5 resume", d, 4);

        // R6: buffers wait for the period end
        bus_wr(0, 0); bus_wr(1, 4); bus_wr(3, 2);
        bus_wr(0, 8'h01);
        bus_wr(5, 0);
        step(2'b01, 2);
        bus_wr(1, 6); bus_wr(3, 5);
        step(2'b01, 1);
        check("R6 duty not yet active", int'(pwm_o[0]), 1);
        step(2'b01, 1);
        bus_rd(5, d); check("R6 wrap on old period", d, 0);
        step(2'b01, 4);
        bus_rd(5, d); check("R6 new period in use", d, 4);
        check("R6 new duty in use", int'(pwm_o[0]), 0);
        step(2'b01, 2);
        bus_rd(5, d); check("R6 wrap on new period", d, 0);

        // R4 R8: counter write in center mode while counting down
        bus_wr(0, 0); bus_wr(1, 4); bus_wr(3, 2);
        bus_wr(0, 8'h15);
        bus_wr(5, 0);
        step(2'b01, 6);
        bus_rd(5, d); check("R3 down phase", d, 2);
        bus_wr(1, 3);
        bus_wr(5, 8'h77);
        bus_rd(5, d); check("R4 counter cleared", d, 0);
        check("R4 pin at polarity level", int'(pwm_o[0]), 1);
        step(2'b01, 1);
        bus_rd(5, d); check("R4 direction up", d, 1);
        for (int i = 0; i < 3; i++) begin
            bus_rd(5, d); check("R8 read leaves count", d, 1);
        end
        step(2'b01, 2);
        bus_rd(5, d); check("R4 peak of new period", d, 3);
        step(2'b01, 1);
        bus_rd(5, d); check("R4 immediate period load", d, 2);

        // R9 R10: chained 16-bit channel, period 300, duty 150, polarity 1
        bus_wr(0, 8'h48);
        bus_wr(1, 8'h2C); bus_wr(2, 8'h01);
        bus_wr(3, 8'h96); bus_wr(4, 8'h00);
        bus_wr(0, 8'h4A);
        bus_wr(5, 0);
        step(2'b10, 100);
        check("R9 chained pin active", int'(pwm_o[1]), 1);
        check("R9 pin 0 held low", int'(pwm_o[0]), 0);
        step(2'b01, 3);
        bus_rd(6, d); check("R9 high byte", d, 0);
        bus_rd(5, d); check("R9 tick0 ignored", d, 100);
        step(2'b10, 154);
        bus_rd(6, d); check("R10 high byte at 254", d, 0);
        step(2'b10, 5);
        bus_rd(5, d); check("R10 latched low byte", d, 8'hFE);
        bus_rd(5, d); check("R10 live low byte", d, 8'h03);
        bus_rd(6, d); check("R9 carry into high byte", d, 1);
        check("R9 chained pin inactive", int'(pwm_o[1]), 0);
        step(2'b10, 41);
        bus_rd(6, d); check("R9 16-bit wrap high", d, 0);
        bus_rd(5, d); check("R9 16-bit wrap low", d, 0);
        step(2'b10, 7);
        bus_wr(6, 8'h3C);
        bus_rd(6, d); check("R9 high write clears high", d, 0);
        bus_rd(5, d); check("R9 high write clears low", d, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule